// File: doc/BRIEF.md
# Exponential-Decay Deconvolution Shaper

This block shapes a continuous stream of signed 16-bit ADC samples, one per clock at most, taken from a resistor-reset charge preamplifier. The preamplifier answers each hit with a fast edge followed by an exponential decay whose time constant is about 2500 sample periods. The first stage adds back the charge lost to that decay. It combines a window difference with a running sum of the last M samples, scaled by a programmable reciprocal of the time constant, so each pulse becomes a flat step. The second stage takes the difference of that step against itself L samples earlier, which gives a near-rectangular pulse L samples long. The height of that pulse tracks the pulse energy.

Inputs that are already shaped in analog can skip the arithmetic through a raw path. The raw path has the same one-clock latency and the same valid rule. Any change to the window lengths, the reciprocal or the path choice restarts the filter from an empty history.

Top module: `mwd_shaper`

## Requirements
- R1: While reset is held, and right after it is released, out_valid is 0 and out_sample is 0.
- R2: Each sample accepted with in_valid high gives its result on out_sample exactly one clock later. In a clock that follows a cycle with in_valid low, out_valid is 0.
- R3: Count samples from 0 since the last restart. The result for sample n is flagged valid only when n ≥ win_m + win_l. Legal window lengths are 1 to 1024.
- R4: In shaped mode (bypass = 0), treat samples older than the last restart as zero. Let S[n] be the sum of x[n−win_m] to x[n−1]. Let D[n] = (x[n] − x[n−win_m])·2^18 + tau_recip·S[n], where tau_recip is unsigned with 18 fractional bits. The output is floor((D[n] − D[n−win_l]) / 2^18).
- R5: A configuration change discards all stored history. Results after the change depend only on samples received after it.
- R6: No internal sum wraps. A result above 8388607 comes out as 8388607, and a result below −8388608 comes out as −8388608.
- R7: With bypass = 1, out_sample is the input sample sign-extended to 24 bits. It keeps the same latency and the same valid rule as the shaped path.
- R8: Changing any of bypass, tau_recip, win_m or win_l counts as a restart. out_valid is 0 in the clock that follows the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_sample carries a new sample this clock |
| in_sample | input | 16 | Signed ADC sample |
| bypass | input | 1 | 1 selects the raw path, 0 the shaped path |
| tau_recip | input | 18 | Reciprocal of the decay constant in samples, 18 fractional bits |
| win_m | input | 11 | Deconvolution window length, 1 to 1024 |
| win_l | input | 11 | Differencing length, 1 to 1024 |
| out_valid | output | 1 | out_sample holds a valid result |
| out_sample | output | 24 | Signed shaped or raw result, saturated |

## Verification
Random signed samples with random idle gaps, run with small windows and with the shortest window of 1, separate the window bookkeeping and the valid rule from the arithmetic. Synthetic exponential pulses at the realistic decay constant exercise the tail cancellation with long windows. A change of only the differencing length partway through the stream shows that the old history is dropped. A long run of zeros followed by full-scale positive, then full-scale negative, samples drives the sums to their largest size: a wrap there would show up as a wrong sign instead of a clamped output. A bypass run with random samples confirms the raw path copies the input with the same timing.

// File: rtl/mwd_pkg.sv
`timescale 1ns/1ps
package mwd_pkg;
  typedef enum logic {PATH_SHAPE = 1'b0, PATH_RAW = 1'b1} path_e;
endpackage

// File: rtl/mwd_history.sv
`timescale 1ns/1ps
// Circular delay line: dout is the sample pushed dly pushes ago (dly = DEPTH
// reads the slot about to be overwritten). Gated to zero when not ok.
module mwd_history #(
  parameter int W     = 16,
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic [$clog2(DEPTH)-1:0]   dly,
  input  logic                       ok,
  output logic [W-1:0]               dout
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wp <= '0;
    else if (push) wp <= wp + 1'b1;
  end

  assign rp   = wp - dly;
  assign dout = ok ? mem[rp] : '0;
endmodule

// File: rtl/mwd_deconv.sv
`timescale 1ns/1ps
// Tail-cancelling stage: D = (x - x_old)*2^KW + k*S, S = running window sum.
module mwd_deconv #(
  parameter int XW    = 16,
  parameter int KW    = 18,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = XW + AW + 1,
  parameter int DW    = SW + KW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 restart,
  input  logic signed [XW-1:0] x,
  input  logic [KW-1:0]        k,
  input  logic [AW:0]          m,
  input  logic                 old_ok,
  output logic signed [DW-1:0] d_out
);
  logic signed [XW-1:0] x_old;
  logic signed [XW:0]   step;
  logic signed [SW-1:0] acc_q;
  logic signed [SW-1:0] acc_base;

  mwd_history #(.W(XW), .DEPTH(DEPTH)) u_xline (
    .clk(clk), .rst_n(rst_n), .push(push), .din(x),
    .dly(m[AW-1:0]), .ok(old_ok), .dout(x_old)
  );

  function automatic logic signed [DW-1:0] deconv(
    input logic signed [XW:0]   s,
    input logic [KW-1:0]        kk,
    input logic signed [SW-1:0] a
  );
    logic signed [DW-1:0] lead;
    logic signed [DW-1:0] tail;
    lead = {{(DW-XW-1){s[XW]}}, s} <<< KW;
    tail = $signed({1'b0, kk}) * a;
    return lead + tail;
  endfunction

  assign step     = {x[XW-1], x} - {x_old[XW-1], x_old};
  assign acc_base = restart ? '0 : acc_q;
  assign d_out    = deconv(step, k, acc_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (push)    acc_q <= acc_base + SW'(step);
    else if (restart) acc_q <= '0;
  end

  // Window sum stays within m full-scale samples: it never wraps.
  logic signed [SW:0] acc_wide;
  logic signed [SW:0] acc_mag;
  logic signed [SW:0] acc_lim;
  assign acc_wide = {acc_q[SW-1], acc_q};
  assign acc_mag  = acc_wide[SW] ? -acc_wide : acc_wide;
  assign acc_lim  = $signed({{(SW-AW){1'b0}}, m}) <<< (XW-1);

  // R6
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (acc_mag <= acc_lim));
endmodule

// File: rtl/mwd_diff.sv
`timescale 1ns/1ps
// Differencing stage: y = clamp(floor((D[n] - D[n-L]) / 2^KW)).
module mwd_diff #(
  parameter int KW    = 18,
  parameter int DEPTH = 1024,
  parameter int DW    = 47,
  parameter int OW    = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [DW-1:0] d_in,
  input  logic [AW-1:0]        l,
  input  logic                 old_ok,
  output logic signed [OW-1:0] y,
  output logic                 clip
);
  localparam logic signed [DW:0]   HI_W = (DW+1)'((2**(OW-1)) - 1);
  localparam logic signed [DW:0]   LO_W = -HI_W - 1;
  localparam logic signed [OW-1:0] HI_Y = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] LO_Y = {1'b1, {(OW-1){1'b0}}};

  logic signed [DW-1:0] d_old;
  logic signed [DW:0]   delta;
  logic signed [DW:0]   scaled;

  mwd_history #(.W(DW), .DEPTH(DEPTH)) u_dline (
    .clk(clk), .rst_n(rst_n), .push(push), .din(d_in),
    .dly(l), .ok(old_ok), .dout(d_old)
  );

  function automatic logic signed [OW-1:0] clamp(input logic signed [DW:0] v);
    if (v > HI_W)      return HI_Y;
    else if (v < LO_W) return LO_Y;
    else               return v[OW-1:0];
  endfunction

  assign delta  = {d_in[DW-1], d_in} - {d_old[DW-1], d_old};
  assign scaled = delta >>> KW;
  assign y      = clamp(scaled);
  assign clip   = (scaled > HI_W) || (scaled < LO_W);
endmodule

// File: rtl/mwd_shaper.sv
`timescale 1ns/1ps
module mwd_shaper
  import mwd_pkg::*;
#(
  parameter int XW    = 16,
  parameter int KW    = 18,
  parameter int DEPTH = 1024,
  parameter int OW    = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic signed [XW-1:0]          in_sample,
  input  logic                          bypass,
  input  logic [KW-1:0]                 tau_recip,
  input  logic [$clog2(DEPTH):0]        win_m,
  input  logic [$clog2(DEPTH):0]        win_l,
  output logic                          out_valid,
  output logic signed [OW-1:0]          out_sample
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int NW  = AW + 2;
  localparam int SW  = XW + AW + 1;
  localparam int DW  = SW + KW + 2;
  localparam int CFW = 1 + KW + 2*CW;
  localparam logic signed [OW-1:0] OUT_HI = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] OUT_LO = {1'b1, {(OW-1){1'b0}}};

  path_e                mode;
  logic [CFW-1:0]       cfg_now;
  logic [CFW-1:0]       cfg_q;
  logic                 restart;
  logic [NW-1:0]        cnt;
  logic [NW-1:0]        n_eff;
  logic [NW-1:0]        warm_lim;
  logic                 x_old_ok;
  logic                 d_old_ok;
  logic                 ready;
  logic signed [DW-1:0] d_val;
  logic signed [OW-1:0] y_shape;
  logic                 clip;

  assign mode     = bypass ? PATH_RAW : PATH_SHAPE;
  assign cfg_now  = {bypass, tau_recip, win_m, win_l};
  assign restart  = (cfg_now != cfg_q);
  assign n_eff    = restart ? '0 : cnt;
  assign warm_lim = NW'(win_m) + NW'(win_l);
  assign x_old_ok = n_eff >= NW'(win_m);
  assign d_old_ok = n_eff >= NW'(win_l);
  assign ready    = n_eff >= warm_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt   <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (in_valid)     cnt <= ready ? n_eff : n_eff + 1'b1;
      else if (restart) cnt <= '0;
    end
  end

  mwd_deconv #(.XW(XW), .KW(KW), .DEPTH(DEPTH)) u_deconv (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .restart(restart),
    .x(in_sample), .k(tau_recip), .m(win_m), .old_ok(x_old_ok), .d_out(d_val)
  );

  mwd_diff #(.KW(KW), .DEPTH(DEPTH), .DW(DW), .OW(OW)) u_diff (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .d_in(d_val),
    .l(win_l[AW-1:0]), .old_ok(d_old_ok), .y(y_shape), .clip(clip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid && ready;
      if (in_valid)
        out_sample <= (mode == PATH_RAW) ? OW'(in_sample) : y_shape;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid);

  // R7
  raw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> (out_sample == OW'($past(in_sample))));

  // R6
  clip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bypass && clip) |=> (out_sample == OUT_HI || out_sample == OUT_LO));
endmodule

// File: tb/test_mwd_shaper.sv
`timescale 1ns/1ps
module test_mwd_shaper;
  localparam int KF = 18;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_sample;
  logic               bypass;
  logic [17:0]        tau_recip;
  logic [10:0]        win_m;
  logic [10:0]        win_l;
  logic               out_valid;
  logic signed [23:0] out_sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int n_idx  = 0;
  int cm, cl, ck;
  bit cb;
  int     xh [0:4095];
  longint dh [0:4095];

  always #10 clk = ~clk;

  mwd_shaper i_mwd_shaper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .bypass(bypass), .tau_recip(tau_recip), .win_m(win_m), .win_l(win_l),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int m, input int l, input int k, input bit b);
    win_m = m[10:0]; win_l = l[10:0]; tau_recip = k[17:0]; bypass = b;
    cm = m; cl = l; ck = k; cb = b;
    n_idx = 0;
    @(negedge clk);
    chk("R8 valid low after change", longint'(out_valid), 0);
  endtask

  task automatic idle(input int c);
    repeat (c) begin
      @(negedge clk);
      chk("R2 no output without input", longint'(out_valid), 0);
    end
  endtask

  task automatic send(input int x, input string tag);
    longint s, d, dold, y;
    int xo;
    bit ev;
    in_sample = x[15:0];
    in_valid  = 1'b1;
    xo = (n_idx >= cm) ? xh[n_idx-cm] : 0;
    s = 0;
    for (int j = n_idx - cm; j < n_idx; j++) if (j >= 0) s += xh[j];
    d = longint'(x - xo) * 64'sd262144 + longint'(ck) * s;
    dold = (n_idx >= cl) ? dh[n_idx-cl] : 0;
    y = (d - dold) >>> KF;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    xh[n_idx] = x;
    dh[n_idx] = d;
    @(negedge clk);
    in_valid = 1'b0;
    ev = (n_idx >= cm + cl);
    chk("R2/R3 valid timing", longint'(out_valid), longint'(ev));
    if (ev) chk(tag, longint'(out_sample), cb ? longint'(x) : y);
    n_idx++;
  endtask

  function automatic int rnd16();
    logic signed [15:0] r;
    r = $urandom;
    return int'(r);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    real v;
    void'($urandom(32'd5150));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    bypass = 1'b0; tau_recip = '0; win_m = 11'd1; win_l = 11'd1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", longint'(out_valid), 0);
    chk("R1 reset sample", longint'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", longint'(out_valid), 0);
    chk("R1 sample after release", longint'(out_sample), 0);

    // random stream with gaps
    cfg(16, 8, 105, 1'b0);
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 4 == 0) idle(1);
      send(rnd16(), "R4 random shaped");
    end

    // shortest windows
    cfg(1, 1, 262143, 1'b0);
    for (int i = 0; i < 100; i++) send(rnd16(), "R4 unit windows");

    // exponential pulses at the realistic decay constant
    cfg(200, 100, 105, 1'b0);
    for (int t = 0; t < 900; t++) begin
      v = 0.0;
      if (t >= 50)  v += 12000.0 * $exp(-(t - 50) / 2500.0);
      if (t >= 500) v += 8000.0 * $exp(-(t - 500) / 2500.0);
      send(int'(v) + int'($urandom % 9) - 4, "R4 exponential pulses");
    end

    // only the differencing length changes: old history must be dropped
    cfg(200, 50, 105, 1'b0);
    for (int t = 0; t < 400; t++) begin
      v = 9000.0 * $exp(-(t + 300) / 2500.0);
      if (t >= 120) v += 15000.0 * $exp(-(t - 120) / 2500.0);
      send(int'(v), "R5 history discarded");
    end

    // positive clipping after a quiet stretch
    cfg(1024, 1024, 262143, 1'b0);
    for (int i = 0; i < 2048; i++) send(0, "R6 quiet");
    for (int i = 0; i < 1024; i++) send(32767, "R6 clip high");
    chk("R6 clamp at top", longint'(out_sample), 8388607);

    // negative clipping
    cfg(1024, 1024, 262142, 1'b0);
    for (int i = 0; i < 2048; i++) send(0, "R6 quiet");
    for (int i = 0; i < 1024; i++) send(-32768, "R6 clip low");
    chk("R6 clamp at bottom", longint'(out_sample), -8388608);

    // raw path
    cfg(4, 3, 500, 1'b1);
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 5 == 0) idle(1);
      send(rnd16(), "R7 bypass copy");
    end
    send(-32768, "R7 bypass negative extreme");
    send(32767, "R7 bypass positive extreme");

    idle(3);
    finish_run();
  end
endmodule